// File: doc/BRIEF.md
# Pipelined SPI Byte-Register Access Slave

This block lets an SPI host read and write a 64-byte register space. Each transfer is one 16-bit full-duplex frame, bounded by an active-low chip select. A write frame names an address and a byte and completes inside that frame. A read frame only names the address. Its data comes back in the following frame, and that following frame is itself decoded as a new command. A host can therefore stream reads back to back, each frame collecting the result of the one before.

The returned word is always a byte pair. The odd-addressed byte comes first and the even-addressed byte second. A read aimed at either address of a pair returns the same word. On the chip side the block presents a plain byte-wide register bus: one address output, a write data byte with a single-cycle write enable, and a combinational read-data input from the register file.

SPI signals are brought into the system clock through synchronizers. The bus runs in mode 3 (clock idles high, data launched on the falling edge and captured on the rising edge), most significant bit first.

Top module: `spiRegSlave`

## Requirements
- R1: Mode 3, MSB first. `mosi` is captured on rising `sclk` edges. `miso` changes only after a falling `sclk` edge and reads 0 from chip-select fall until the first falling edge.
- R2: A complete frame with bit 15 = 1 produces exactly one `regWrEn` pulse of one system clock. During that pulse `regAddr` = frame bits 13:8 and `regWrData` = frame bits 7:0.
- R3: Frame bit 14 has no effect on decode, on the write address or on the read address.
- R4: A complete frame with bit 15 = 0 is a read of address bits 13:8. It produces no write pulse, and its bits 7:0 are ignored.
- R5: The word returned for a read of address A is `{byte[A|1], byte[A&~1]}`, with the odd byte sent first. A and A^1 return the same word.
- R6: The read word is shifted out during the next frame, and that frame is decoded as a new command. Consecutive reads therefore each return the previous frame's target.
- R7: After reset, and in the frame after a complete write frame, `miso` shifts out 16 zeros.
- R8: A frame whose chip select rises after fewer than 16 rising `sclk` edges is discarded. It causes no write, and the next frame returns zeros.
- R9: The read word is fetched when chip select falls. A write completed in the returning frame is not reflected in that frame's data.
- R10: Out of reset `miso` = 0 and `regWrEn` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | SPI serial clock, idles high |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| regAddr | output | 6 | Register bus byte address |
| regWrData | output | 8 | Register bus write byte |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdData | input | 8 | Register bus read byte for `regAddr` |

## Verification
The bench follows a read with a write to the same byte pair in the returning frame. A design that fetched late, at the frame end, would return the new value instead of the old one. Reads target both the even and the odd address of a pair and set bit 14. A design with the byte order swapped, or one that decoded bit 14 into the address, would return or write the wrong bytes. Aborted frames are sent both as writes and after a pending read. A design that kept partial frames would produce stray writes or stale read data where zeros are required.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef struct packed {
    logic frameStart;
    logic shiftIn;
    logic mosiBit;
    logic shiftOut;
    logic loadHi;
    logic loadLo;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_HI,
    FS_LO
  } fetchState_t;

endpackage

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [DATA_W-1:0]     rdData,
  output logic [2*DATA_W-1:0]   rxWord,
  output logic                  misoOut
);

  localparam int FRAME_W = 2 * DATA_W;

  logic [FRAME_W-1:0] rxReg;
  logic [FRAME_W-1:0] txReg;
  logic               misoReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '0;
      misoReg <= 1'b0;
    end else begin
      if (strobe.frameStart) begin
        txReg   <= '0;
        misoReg <= 1'b0;
      end else begin
        if (strobe.loadHi) txReg[FRAME_W-1:DATA_W] <= rdData;
        if (strobe.loadLo) txReg[DATA_W-1:0]       <= rdData;
        if (strobe.shiftOut) begin
          misoReg <= txReg[FRAME_W-1];
          txReg   <= {txReg[FRAME_W-2:0], 1'b0};
        end
      end
      if (strobe.shiftIn) rxReg <= {rxReg[FRAME_W-2:0], strobe.mosiBit};
    end
  end

  assign rxWord  = rxReg;
  assign misoOut = misoReg;

  // Word capture and serial launch never overlap (R6)
  p_load_vs_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftOut |-> !(strobe.loadHi || strobe.loadLo));

endmodule

// File: rtl/spiRegControl.sv
module spiRegControl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclk,
  input  logic                  csN,
  input  logic                  mosi,
  input  logic [2*DATA_W-1:0]   rxWord,
  output dpStrobe_t             strobe,
  output logic [ADDR_W-1:0]     regAddr,
  output logic [DATA_W-1:0]     regWrData,
  output logic                  regWrEn
);

  localparam int FRAME_W = 2 * DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  // synchronizers, one extra stage on clock and select for edge detection
  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES:0]   csPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '1;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-1:0], csN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
    end
  end

  logic sclkRise, sclkFall, csFall, csRise, csActive;
  assign sclkRise = sclkPipe[SYNC_STAGES-1] & ~sclkPipe[SYNC_STAGES];
  assign sclkFall = ~sclkPipe[SYNC_STAGES-1] & sclkPipe[SYNC_STAGES];
  assign csFall   = ~csPipe[SYNC_STAGES-1] & csPipe[SYNC_STAGES];
  assign csRise   = csPipe[SYNC_STAGES-1] & ~csPipe[SYNC_STAGES];
  assign csActive = ~csPipe[SYNC_STAGES-1];

  logic [CNT_W-1:0]  bitCnt;
  logic              doneQ;
  logic              pendRd;
  logic [ADDR_W-1:0] pendAddr;
  fetchState_t       fState;

  logic              cmdWrite;
  logic [ADDR_W-1:0] cmdAddr;
  logic              bitsLeft;
  assign cmdWrite = rxWord[FRAME_W-1];
  assign cmdAddr  = rxWord[DATA_W+ADDR_W-1:DATA_W];
  assign bitsLeft = (bitCnt < FULL_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      doneQ    <= 1'b0;
      pendRd   <= 1'b0;
      pendAddr <= '0;
      fState   <= FS_IDLE;
    end else begin
      doneQ <= csActive && sclkRise && (bitCnt == LAST_BIT);
      if (csFall) bitCnt <= '0;
      else if (csActive && sclkRise && bitsLeft) bitCnt <= bitCnt + 1'b1;

      if (doneQ) begin
        pendRd   <= ~cmdWrite;
        pendAddr <= cmdAddr;
      end else if (csRise && bitCnt != FULL_CNT) begin
        pendRd <= 1'b0;
      end

      unique case (fState)
        FS_IDLE: if (csFall && pendRd) fState <= FS_HI;
        FS_HI:   fState <= FS_LO;
        default: fState <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.frameStart = csFall;
    strobe.shiftIn    = csActive && sclkRise && bitsLeft;
    strobe.mosiBit    = mosiPipe[SYNC_STAGES-1];
    strobe.shiftOut   = csActive && sclkFall && bitsLeft;
    strobe.loadHi     = (fState == FS_HI);
    strobe.loadLo     = (fState == FS_LO);
  end

  always_comb begin
    unique case (fState)
      FS_HI:   regAddr = {pendAddr[ADDR_W-1:1], 1'b1};
      FS_LO:   regAddr = {pendAddr[ADDR_W-1:1], 1'b0};
      default: regAddr = cmdAddr;
    endcase
  end

  assign regWrData = rxWord[DATA_W-1:0];
  assign regWrEn   = doneQ && cmdWrite;

  // one strobe per write frame (R2)
  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
  // bit counter saturates at one frame (R1)
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);
  // odd byte fetched, then even byte (R5)
  p_fetch_seq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fState == FS_HI) |=> (fState == FS_LO));
  // short frame leaves no read pending (R8)
  p_abort_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && bitCnt != FULL_CNT && !doneQ) |=> !pendRd);
  // a fetch starts only at a frame start (R9)
  p_fetch_at_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fState == FS_HI) |-> $past(csFall));

endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [DATA_W-1:0] regRdData
);

  dpStrobe_t           strobe;
  logic [2*DATA_W-1:0] rxWord;

  spiRegControl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .rxWord(rxWord), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn)
  );

  spiRegDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(regRdData),
    .rxWord(rxWord), .misoOut(miso)
  );

endmodule

// File: tb/sim_spiRegSlave.sv
module sim_spiRegSlave;

  localparam int HALF = 10;
  localparam int NV   = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b1;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic [5:0] regAddr;
  logic [7:0] regWrData;
  logic regWrEn;
  logic [7:0] regRdData;

  always #2 clk = ~clk;

  spiRegSlave u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData)
  );

  logic [7:0] mem [64];
  int wrCount = 0;
  logic [5:0] lastWrAddr = '0;
  logic [7:0] lastWrData = '0;
  initial for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  always @(posedge clk) if (regWrEn) begin
    mem[regAddr] <= regWrData;
    wrCount      <= wrCount + 1;
    lastWrAddr   <= regAddr;
    lastWrData   <= regWrData;
  end
  assign regRdData = mem[regAddr];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doFrame(input logic [15:0] tx, input int nBits,
                         output logic [15:0] rx, output logic preMiso);
    rx = '0;
    @(negedge clk) csN = 1'b0;
    repeat (12) @(negedge clk);
    preMiso = miso;
    for (int i = 0; i < nBits; i++) begin
      sclk = 1'b0;
      mosi = tx[15-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[14:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    csN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // frame sequence and the word each frame must return
  localparam logic [15:0] CMDS [NV] = '{
    16'h825A, 16'hC3C3, 16'h02FF, 16'h0300, 16'hBF11, 16'h7E00, 16'hBE22,
    16'h3F00, 16'h9077, 16'h1100, 16'h1000, 16'h0200, 16'h8000};
  localparam logic [15:0] EXPS [NV] = '{
    16'h0000, 16'h0000, 16'h0000, 16'hC35A, 16'hC35A, 16'h0000, 16'h1100,
    16'h0000, 16'h1122, 16'h0000, 16'h0077, 16'h0077, 16'hC35A};

  initial begin
    logic [15:0] rx;
    logic pre;
    int wBefore;
    repeat (5) @(negedge clk);
    check("R10 miso reset", 32'(miso), 32'h0);
    check("R10 wrEn reset", 32'(regWrEn), 32'h0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wBefore = wrCount;
      doFrame(CMDS[v], 16, rx, pre);
      check("R5 R6 R7 R9 returned word", 32'(rx), 32'(EXPS[v]));
      check("R1 miso idle before first fall", 32'(pre), 32'h0);
      if (CMDS[v][15]) begin
        check("R2 one write pulse", 32'(wrCount - wBefore), 32'd1);
        check("R2 R3 write address", 32'(lastWrAddr), 32'(CMDS[v][13:8]));
        check("R2 write data", 32'(lastWrData), 32'(CMDS[v][7:0]));
      end else begin
        check("R4 read makes no write", 32'(wrCount - wBefore), 32'd0);
      end
    end

    // R8: short write frame is dropped
    wBefore = wrCount;
    doFrame(16'h85AA, 10, rx, pre);
    check("R8 aborted write no strobe", 32'(wrCount - wBefore), 32'd0);
    check("R8 aborted write no store", 32'(mem[5]), 32'h00);
    // R8: a read followed by a short frame loses its data
    doFrame(16'h0300, 16, rx, pre);
    doFrame(16'h0300, 7, rx, pre);
    doFrame(16'h0000, 16, rx, pre);
    check("R8 zeros after abort", 32'(rx), 32'h0000);
    // R7: back after a read returns the pair at 00/01
    doFrame(16'h8000, 16, rx, pre);
    check("R6 read of 00 returned", 32'(rx), 32'h0000);
    doFrame(16'h0300, 16, rx, pre);
    check("R7 zeros after write", 32'(rx), 32'h0000);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule